// File: doc/BRIEF.md
# Line Channel Interrupt Status Unit

This block gathers the event and status bits of one line-interface channel, filters the slow mechanical inputs and reports changes to a host through a small register port and an active-low interrupt line. The loop-closure (hook) input and the general-purpose IO inputs pass through debounce counters whose lengths the host programs. The levelmeter threshold and ready flags and the tone-detector results are sampled directly. Every status bit is re-evaluated only on a 2 kHz frame strobe (`tick`), so a change can reach the host up to one frame late.

The interrupt fires when any source bit changes in either direction and its mask bit is clear. A masked bit keeps updating in its status register but raises nothing. The host services the interrupt by reading all three status registers, in any order. After the last of those reads the line releases, the channel flag clears and the reset-status bit clears. A change that arrives while such a read sequence is still open is held back. It is raised as a new interrupt after the line has been released for one cycle.

Register map (3-bit address, 8-bit data): 0 = STATUS_A, 1 = STATUS_B, 2 = STATUS_C (read-only), 3 = IO debounce length, 4/5/6 = mask for STATUS_A/B/C (1 = masked), 7 = hook debounce length. Debounce lengths count frame strobes.

Top module: `line_irq_status`

## Requirements
- R1: Debounced values and sampled status bits change only at a clock edge where `tick` is high. Between strobes, input changes reach neither the status registers nor `irq_n`.
- R2: When a source bit changes in either direction and its mask bit is clear, `irq_n` goes low one clock after the status bit updates. The source bits are STATUS_A bit0 hook, bit1 level threshold, bit2 level ready; STATUS_B bits3:0 IO; STATUS_C bits1:0 tone.
- R3: A set mask bit (registers 4..6, same bit position as the status bit) blocks only the interrupt. The status bit still updates.
- R4: A read with `rd_en` returns data with `rd_valid` on the next cycle. `irq_n` returns high in the cycle after all three status registers (addresses 0, 1, 2) have been read.
- R5: STATUS_A bit7 is the channel flag. It is 1 whenever `irq_n` is low and it clears when a read sequence completes.
- R6: A change that occurs after the first and before the last read of a sequence is held. `irq_n` goes high for one cycle after the sequence completes, then goes low again.
- R7: After reset, `irq_n` is low, STATUS_B reads 0x20 (bit5 = reset status) and STATUS_A reads 0x80. All masks read 0x00, the hook length reads 20 and the IO length reads 33. The reset bit clears when a read sequence completes.
- R8: The debounced hook value takes the raw value at the N-th consecutive strobe at which the two differ, N being register 7 (0 acts as 1). A strobe at which they agree restarts the count.
- R9: Each IO input is debounced in the same way with length register 3, and the result appears in STATUS_B bits3:0.
- R10: Writes to status addresses 0..2 have no effect on the readable status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 2 kHz frame strobe, one cycle wide |
| hook_raw | input | 1 | Unfiltered hook state |
| gpio_raw | input | NIO (4) | Unfiltered IO pin states |
| lm_thresh | input | 1 | Levelmeter result above threshold |
| lm_ready | input | 1 | Levelmeter result ready |
| tone_det | input | NTONE (2) | Tone-detector results |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle the assertions check these properties: filtered values move only on a strobe and never away from an agreeing raw input, an unmasked change drops the line on the next cycle, a completed read sequence releases it, and the channel flag is set whenever the line is low. Only the bench scenarios can show the exact debounce lengths, the restart of a count after a glitch, and that masked bits still update. They also cover the held change that comes back after its one-cycle release and the reset-time register contents.

// File: rtl/lis_pkg.sv
// Package: shared widths, register addresses and status bit positions of
// the line interrupt status unit. Assumes three 8-bit status registers.
package lis_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_STAT = 3;
    localparam int VEC_W    = REG_W * NUM_STAT;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_STAT0  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT1  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT2  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IO_DB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK0  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HOOK_DB = 3'd7;

    localparam int B_HOOK  = 0;
    localparam int B_LMTHR = 1;
    localparam int B_LMRDY = 2;
    localparam int B_FLAG  = 7;
    localparam int B_RST   = REG_W + 5;
    localparam int B_GPIO  = REG_W;
    localparam int B_TONE  = 2 * REG_W;

    // Which bits of the flat status vector are interrupt sources.
    function automatic logic [VEC_W-1:0] src_mask(input int nio, input int ntone);
        logic [VEC_W-1:0] m;
        m = '0;
        m[B_HOOK]  = 1'b1;
        m[B_LMTHR] = 1'b1;
        m[B_LMRDY] = 1'b1;
        for (int i = 0; i < nio; i++)   m[B_GPIO + i] = 1'b1;
        for (int i = 0; i < ntone; i++) m[B_TONE + i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lis_debounce.sv
// Debounce filter: the output takes the raw value once the raw value has
// differed from it at `limit` consecutive frame strobes. A strobe at which
// they agree restarts the count. Assumes raw is already synchronous.
module lis_debounce #(
    parameter int   CNT_W   = 8,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             filt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   lim_eff;

    // Zero length behaves as one strobe.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        lim_eff = (limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit};
    end

    // Count disagreeing strobes and take the raw value at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            filt  <= RST_VAL;
        end else if (tick) begin
            if (raw == filt) begin
                cnt_q <= '0;
            end else if (cnt_inc >= lim_eff) begin
                filt  <= raw;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt)); // R1
    AST_DB_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && raw == filt) |=> $stable(filt)); // R8
endmodule

// File: rtl/lis_regs.sv
// Register port: holds the mask and debounce-length registers, returns read
// data one cycle after rd_en, and flags reads of the three status registers.
// Assumes rd_en and wr_en are single-cycle strobes from the host.
module lis_regs
    import lis_pkg::*;
#(
    parameter int HOOK_DB_DEF = 20,
    parameter int IO_DB_DEF   = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [VEC_W-1:0]    stat_vec,
    output logic [VEC_W-1:0]    mask_vec,
    output logic [REG_W-1:0]    hook_lim,
    output logic [REG_W-1:0]    io_lim,
    output logic [NUM_STAT-1:0] read_hit,
    output logic [REG_W-1:0]    rdata,
    output logic                rd_valid
);
    logic [REG_W-1:0] mask_q [NUM_STAT];
    logic [REG_W-1:0] rd_mux;

    // Per-register read strobe for the status registers and mask flattening.
    generate
        for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
            assign read_hit[k] = rd_en && (addr == A_STAT0 + ADDR_W'(k));
            assign mask_vec[k*REG_W +: REG_W] = mask_q[k];
        end
    endgenerate

    // Host writes to masks and debounce lengths; status addresses ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_STAT; k++) mask_q[k] <= '0;
            hook_lim <= REG_W'(HOOK_DB_DEF);
            io_lim   <= REG_W'(IO_DB_DEF);
        end else if (wr_en) begin
            for (int k = 0; k < NUM_STAT; k++)
                if (addr == A_MASK0 + ADDR_W'(k)) mask_q[k] <= wdata;
            if (addr == A_HOOK_DB) hook_lim <= wdata;
            if (addr == A_IO_DB)   io_lim   <= wdata;
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_STAT; k++) begin
            if (addr == A_STAT0 + ADDR_W'(k)) rd_mux = stat_vec[k*REG_W +: REG_W];
            if (addr == A_MASK0 + ADDR_W'(k)) rd_mux = mask_q[k];
        end
        if (addr == A_HOOK_DB) rd_mux = hook_lim;
        if (addr == A_IO_DB)   rd_mux = io_lim;
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

    AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R4
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R4
endmodule

// File: rtl/lis_event_ctl.sv
// Event control: detects changes of source bits, keeps unmasked ones pending
// and drives the interrupt. It tracks the host's read sequence over the
// status registers and holds changes that arrive mid-sequence. Assumes the
// source vector moves only on frame strobes.
module lis_event_ctl #(
    parameter int                VEC_W    = 24,
    parameter int                NUM_STAT = 3,
    parameter logic [VEC_W-1:0]  SRC_MASK = '1,
    parameter logic [VEC_W-1:0]  PEND_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VEC_W-1:0]    src,
    input  logic [VEC_W-1:0]    mask,
    input  logic [NUM_STAT-1:0] read_hit,
    output logic                irq_n,
    output logic                chan_flag,
    output logic                rst_flag
);
    logic [VEC_W-1:0]    prev_q, pend_q, held_q, chg, pend_d, held_d;
    logic [NUM_STAT-1:0] seen_q, seen_acc, seen_d;
    logic                done, in_seq, flag_d;

    // Next-state logic for pending, held and read-sequence tracking.
    always_comb begin
        chg      = (src ^ prev_q) & SRC_MASK & ~mask;
        seen_acc = seen_q | read_hit;
        done     = &seen_acc;
        in_seq   = |seen_acc;
        seen_d   = done ? '0 : seen_acc;
        if (done) begin
            pend_d = '0;
            held_d = held_q | chg;
            flag_d = 1'b0;
        end else if (in_seq) begin
            pend_d = pend_q;
            held_d = held_q | chg;
            flag_d = chan_flag | (|pend_q);
        end else begin
            pend_d = pend_q | held_q | chg;
            held_d = '0;
            flag_d = chan_flag | (|pend_d);
        end
    end

    // State registers; reset leaves the reset-status event pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            pend_q    <= PEND_RST;
            held_q    <= '0;
            seen_q    <= '0;
            chan_flag <= 1'b1;
            rst_flag  <= 1'b1;
        end else begin
            prev_q    <= src;
            pend_q    <= pend_d;
            held_q    <= held_d;
            seen_q    <= seen_d;
            chan_flag <= flag_d;
            if (done) rst_flag <= 1'b0;
        end
    end

    assign irq_n = ~(|pend_q);

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chg) && !done && !in_seq) |=> !irq_n); // R2
    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_n); // R4
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> chan_flag); // R5
    AST_RST_FLAG_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_flag |=> !rst_flag); // R7
endmodule

// File: rtl/line_irq_status.sv
// Top: maskable interrupt status unit for one line channel. Debounces hook
// and IO inputs, samples levelmeter and tone flags on the frame strobe,
// builds three status registers and raises irq_n on unmasked changes.
// Assumes NIO <= 5 and NTONE <= 8 so the fields fit their registers.
module line_irq_status
    import lis_pkg::*;
#(
    parameter int NIO         = 4,
    parameter int NTONE       = 2,
    parameter int HOOK_DB_DEF = 20,
    parameter int IO_DB_DEF   = 33
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hook_raw,
    input  logic [NIO-1:0]     gpio_raw,
    input  logic               lm_thresh,
    input  logic               lm_ready,
    input  logic [NTONE-1:0]   tone_det,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               rd_valid,
    output logic               irq_n
);
    localparam logic [VEC_W-1:0] SRC_MASK = src_mask(NIO, NTONE);
    localparam logic [VEC_W-1:0] PEND_RST = VEC_W'(1) << B_RST;

    logic                hook_f, lm_thr_q, lm_rdy_q, chan_flag, rst_flag;
    logic [NIO-1:0]      gpio_f;
    logic [NTONE-1:0]    tone_q;
    logic [VEC_W-1:0]    src_vec, stat_vec, mask_vec;
    logic [REG_W-1:0]    hook_lim, io_lim;
    logic [NUM_STAT-1:0] read_hit;

    lis_debounce #(.CNT_W(REG_W), .RST_VAL(1'b0)) u_hook_db (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(hook_raw),
        .limit(hook_lim), .filt(hook_f));

    generate
        for (genvar i = 0; i < NIO; i++) begin : g_io_db
            lis_debounce #(.CNT_W(REG_W), .RST_VAL(1'b0)) u_io_db (
                .clk(clk), .rst_n(rst_n), .tick(tick), .raw(gpio_raw[i]),
                .limit(io_lim), .filt(gpio_f[i]));
        end
    endgenerate

    // Sample the undebounced flags once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lm_thr_q <= 1'b0;
            lm_rdy_q <= 1'b0;
            tone_q   <= '0;
        end else if (tick) begin
            lm_thr_q <= lm_thresh;
            lm_rdy_q <= lm_ready;
            tone_q   <= tone_det;
        end
    end

    // Assemble source and readable status vectors.
    always_comb begin
        src_vec = '0;
        src_vec[B_HOOK]  = hook_f;
        src_vec[B_LMTHR] = lm_thr_q;
        src_vec[B_LMRDY] = lm_rdy_q;
        src_vec[B_GPIO +: NIO]   = gpio_f;
        src_vec[B_TONE +: NTONE] = tone_q;
        stat_vec = src_vec;
        stat_vec[B_FLAG] = chan_flag;
        stat_vec[B_RST]  = rst_flag;
    end

    lis_regs #(.HOOK_DB_DEF(HOOK_DB_DEF), .IO_DB_DEF(IO_DB_DEF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .stat_vec(stat_vec), .mask_vec(mask_vec),
        .hook_lim(hook_lim), .io_lim(io_lim), .read_hit(read_hit),
        .rdata(rdata), .rd_valid(rd_valid));

    lis_event_ctl #(.VEC_W(VEC_W), .NUM_STAT(NUM_STAT), .SRC_MASK(SRC_MASK),
                    .PEND_RST(PEND_RST)) u_evt (
        .clk(clk), .rst_n(rst_n), .src(src_vec), .mask(mask_vec),
        .read_hit(read_hit), .irq_n(irq_n), .chan_flag(chan_flag),
        .rst_flag(rst_flag));

    AST_SRC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(src_vec)); // R1
endmodule

// File: tb/tb_line_irq_status.sv
module tb_line_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hook_raw = 1'b0;
    logic [3:0] gpio_raw = '0;
    logic       lm_thresh = 1'b0;
    logic       lm_ready = 1'b0;
    logic [1:0] tone_det = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    line_irq_status dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hook_raw(hook_raw),
        .gpio_raw(gpio_raw), .lm_thresh(lm_thresh), .lm_ready(lm_ready),
        .tone_det(tone_det), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq_n(irq_n));

    // Monitor: pops the expected read value whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read response actual %02h expected none", rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rdata !== e.val) begin
                    errors++;
                    $display("FAIL %s read actual %02h expected %02h", e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_all(input logic [7:0] e0, input logic [7:0] e1,
                          input logic [7:0] e2, input string tag);
        rd(3'd0, e0, tag);
        rd(3'd1, e1, tag);
        rd(3'd2, e2, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // One frame strobe, followed by idle cycles.
    task automatic frame();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_irq(input logic v, input string tag);
        checks++;
        if (irq_n !== v) begin
            errors++;
            $display("FAIL %s irq_n actual %0b expected %0b", tag, irq_n, v);
        end
    endtask

    initial begin
        #(150000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk_irq(1'b0, "R7 reset irq");
        rd(3'd4, 8'h00, "R7 mask reset");
        rd(3'd7, 8'd20, "R7 hook length");
        rd(3'd3, 8'd33, "R7 io length");
        chk_irq(1'b0, "R7 non-status reads keep irq");
        rd(3'd0, 8'h80, "R5 flag after reset");
        rd(3'd1, 8'h20, "R7 reset status");
        rd(3'd2, 8'h00, "R7 status c");
        chk_irq(1'b1, "R4 release after sequence");
        rd_all(8'h00, 8'h00, 8'h00, "R7 reset bit cleared");

        wr(3'd7, 8'd3);
        wr(3'd3, 8'd2);
        // R8 hook debounce length
        hook_raw = 1'b1;
        frame(); frame();
        chk_irq(1'b1, "R8 two strobes too few");
        frame();
        chk_irq(1'b0, "R8 third strobe");
        rd_all(8'h81, 8'h00, 8'h00, "R8 hook status");
        chk_irq(1'b1, "R4 release");

        // R8 restart on agreeing strobe
        hook_raw = 1'b0;
        frame(); frame();
        hook_raw = 1'b1; frame();
        hook_raw = 1'b0; frame(); frame();
        chk_irq(1'b1, "R8 count restarted");
        frame();
        chk_irq(1'b0, "R8 falling hook");
        rd_all(8'h80, 8'h00, 8'h00, "R8 hook low");

        // R3 masked bit updates status without interrupt
        wr(3'd4, 8'h02);
        lm_thresh = 1'b1;
        frame();
        chk_irq(1'b1, "R3 masked no irq");
        rd_all(8'h02, 8'h00, 8'h00, "R3 status still updates");

        // R2 falling change unmasked
        wr(3'd4, 8'h00);
        lm_thresh = 1'b0;
        frame();
        chk_irq(1'b0, "R2 falling edge irq");
        rd_all(8'h80, 8'h00, 8'h00, "R2 status");

        // R9 IO debounce
        gpio_raw = 4'b1010;
        frame();
        chk_irq(1'b1, "R9 one strobe too few");
        frame();
        chk_irq(1'b0, "R9 io irq");
        rd_all(8'h80, 8'h0A, 8'h00, "R9 io status");

        // R6 change held during sequence
        tone_det = 2'b01;
        frame();
        chk_irq(1'b0, "R2 tone irq");
        rd(3'd0, 8'h80, "R6 first read");
        tone_det = 2'b11;
        frame();
        chk_irq(1'b0, "R6 still low mid sequence");
        rd(3'd1, 8'h0A, "R6 second read");
        rd(3'd2, 8'h03, "R6 third read");
        chk_irq(1'b1, "R6 released one cycle");
        @(negedge clk);
        chk_irq(1'b0, "R6 held change re-raised");
        rd_all(8'h80, 8'h0A, 8'h03, "R6 replay status");

        // R10 write to status ignored
        wr(3'd2, 8'h00);
        wr(3'd1, 8'hFF);
        rd_all(8'h00, 8'h0A, 8'h03, "R10 writes ignored");

        // R1 no update without strobe
        lm_ready = 1'b1;
        repeat (40) @(negedge clk);
        chk_irq(1'b1, "R1 no strobe no irq");
        rd_all(8'h00, 8'h0A, 8'h03, "R1 status unchanged");
        frame();
        chk_irq(1'b0, "R1 strobe applies change");
        rd_all(8'h84, 8'h0A, 8'h03, "R1 level ready");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard left %0d expected 0", exp_q.size());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule